// File: doc/BRIEF.md
# Transceiver Configuration Serial Master

This engine reads and writes indexed configuration registers inside an external infrared transceiver module over a bit-banged clocked serial link. The link has a clock output, a data output and one data input. A host raises `req` with a device address, a register index, a direction flag and write data. The engine frames a command byte, shifts it out, and then either sends the data byte or polls for an active-low ready indication and captures the reply. A third command, module reset, sends a long burst of clock cycles with the data line held low.

Every serial phase is measured in units of a programmable half period of H system clocks. H is taken from `cfg_half` when a request is accepted. Some phases last H and the longer low phases last 2H. `done` pulses once when the link is back at rest. Read results and their status flags are held until the next request is accepted.

Top module: `xcm_master`

## Requirements
- R1: The command byte is `req_addr | (req_index << 1) | dir`, where dir is 1 for a write and 0 for a read. It goes out least-significant bit first, and each bit is placed on `ser_dout` while `ser_clk` is low and is followed by one rising edge.
- R2: Each read or write first holds `ser_clk` low with `ser_dout` low for 2H. It then gives one start rising edge with `ser_dout` low, before the command bits.
- R3: A write sends the data byte LSB first right after the command byte. It then sends two clock pulses with `ser_dout` low and ends with `ser_clk` low. `done` rises 57H cycles after the accepting edge.
- R4: After a read command the engine gives up to 10 poll pulses with `ser_dout` high. It samples `ser_din` at the end of each pulse's low phase and stops at the first low sample.
- R5: When ready was seen, 8 bits are captured LSB first, each sampled at the end of the low phase that follows a rising edge. `rd_data` then holds the byte and `rd_ok`=1, `rd_timeout`=0 at `done`. A read whose ready comes on poll n completes in (65+2n)H cycles.
- R6: If no poll sample is low, the engine gives 2 dummy pulses and reports `rd_timeout`=1, `rd_ok`=0 and `rd_data`=0. The whole read takes 67H cycles.
- R7: Every read ends with 4 trailer pulses. The first has `ser_dout` high and the remaining three have `ser_dout` low.
- R8: A reset command (`req_reset`=1) gives exactly 30 clock cycles of H high and H low with `ser_dout` low throughout. It ends with the clock low and takes 60H cycles.
- R9: Each clock high phase lasts exactly H system clocks. H is latched from `cfg_half` at acceptance, and a value of 0 is treated as 1.
- R10: `done` is high for exactly one cycle. Request fields are latched at acceptance, so later changes have no effect. No new request is accepted in the cycle in which `done` is high.
- R11: Synchronous `rst` drives `ser_clk`, `ser_dout` and `done` low and abandons any transaction. No completion follows while `req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | HW | Half period in system clocks (0 means 1) |
| req | input | 1 | Request, held high until `done` |
| req_write | input | 1 | 1 write, 0 read |
| req_reset | input | 1 | 1 selects the module-reset burst |
| req_addr | input | DW | Device address bits of the command byte |
| req_index | input | DW-1 | Register index, placed at bit 1 upward |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read byte (0 on timeout) |
| rd_ok | output | 1 | Last read saw ready |
| rd_timeout | output | 1 | Last read timed out |
| ser_clk | output | 1 | Serial clock to the transceiver |
| ser_dout | output | 1 | Serial data to the transceiver |
| ser_din | input | 1 | Serial data / ready from the transceiver |

## Verification
Completion time is fixed by the command, the half period and the poll count. It is 57H for a write, (65+2n)H for a read with ready on poll n, 67H for a timeout and 60H for a reset, counted from the accepting edge. The bench counts system clock edges from that edge and compares the count with these values. A monitor stores the data level and the high-phase length at every rising serial clock edge, and the checks index those records by edge number: start edge 1, command edges 2 to 9, and then the edges that follow. The modelled transceiver derives its reply from the edge count. The engine samples only after a full H low phase, so the stimulus always settles before it is read.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_PRE, S_MARK, S_BLO, S_BHI, S_GAP, S_PHI, S_PLO,
    S_DHI, S_DLO, S_XHI, S_XLO, S_THI, S_TLO, S_WLO, S_WHI,
    S_RHI, S_RLO
  } xcm_state_e;
endpackage

// File: rtl/xcm_timer.sv
module xcm_timer #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dbl,
  input  logic [HW-1:0] half,
  output logic          expire
);
  localparam int TW = HW + 1;
  logic [TW-1:0] cnt;
  logic [TW-1:0] len;

  assign len = dbl ? {half, 1'b0} : {1'b0, half};

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= len - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

  // R9
  tmr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/xcm_rxshift.sv
module xcm_rxshift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          shift,
  input  logic          bit_in,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (shift)  q <= {bit_in, q[DW-1:1]};
  end

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
endmodule

// File: rtl/xcm_master.sv
module xcm_master
  import xcm_pkg::*;
#(
  parameter int HW         = 8,
  parameter int DW         = 8,
  parameter int POLL_MAX   = 10,
  parameter int DUMMY      = 2,
  parameter int WR_TAIL    = 2,
  parameter int RD_TAIL    = 4,
  parameter int RST_PULSES = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfg_half,
  input  logic          req,
  input  logic          req_write,
  input  logic          req_reset,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-2:0] req_index,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          rd_ok,
  output logic          rd_timeout,
  output logic          ser_clk,
  output logic          ser_dout,
  input  logic          ser_din
);
  localparam int CMAX = (RST_PULSES > 2*DW) ? RST_PULSES : 2*DW;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LAST_WR   = CW'(2*DW - 1);
  localparam logic [CW-1:0] LAST_RD   = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(POLL_MAX - 1);
  localparam logic [CW-1:0] LAST_DUM  = CW'(DUMMY - 1);
  localparam logic [CW-1:0] LAST_WT   = CW'(WR_TAIL - 1);
  localparam logic [CW-1:0] LAST_RT   = CW'(RD_TAIL - 1);
  localparam logic [CW-1:0] LAST_RST  = CW'(RST_PULSES - 1);

  xcm_state_e        st, nst;
  logic [CW-1:0]     cnt;
  logic [2*DW-1:0]   sh;
  logic              is_wr, got_rdy;
  logic [HW-1:0]     half_q, half_eff, half_use;
  logic              nclk, ndo, ndbl, adv, fin, accept, expire;
  logic              rx_shift;

  assign half_eff = (cfg_half == '0) ? HW'(1) : cfg_half;
  assign half_use = (st == S_IDLE) ? half_eff : half_q;
  assign accept   = (st == S_IDLE) && req && !done;
  assign rx_shift = (st == S_DLO) && expire;

  xcm_timer #(.HW(HW)) u_timer (
    .clk(clk), .rst(rst), .load(adv && nst != S_IDLE), .dbl(ndbl),
    .half(half_use), .expire(expire)
  );

  xcm_rxshift #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .clr(accept), .shift(rx_shift),
    .bit_in(ser_din), .q(rd_data)
  );

  always_comb begin
    nst = st; nclk = ser_clk; ndo = ser_dout; ndbl = 1'b0;
    adv = 1'b0; fin = 1'b0;
    if (st == S_IDLE) begin
      if (accept) begin
        adv = 1'b1;
        if (req_reset) begin nst = S_RHI; nclk = 1'b1; ndo = 1'b0; end
        else begin nst = S_PRE; nclk = 1'b0; ndo = 1'b0; ndbl = 1'b1; end
      end
    end else if (expire) begin
      adv = 1'b1;
      unique case (st)
        S_PRE:  begin nst = S_MARK; nclk = 1'b1; ndo = 1'b0; end
        S_MARK: begin nst = S_BLO; nclk = 1'b0; ndo = sh[0]; ndbl = 1'b1; end
        S_BLO:  begin nst = S_BHI; nclk = 1'b1; end
        S_BHI: begin
          if (cnt == (is_wr ? LAST_WR : LAST_RD)) begin
            nst = is_wr ? S_WLO : S_GAP; nclk = 1'b0; ndo = 1'b0; ndbl = 1'b1;
          end else begin
            nst = S_BLO; nclk = 1'b0; ndo = sh[1]; ndbl = 1'b1;
          end
        end
        S_GAP:  begin nst = S_PHI; nclk = 1'b1; ndo = 1'b1; end
        S_PHI:  begin nst = S_PLO; nclk = 1'b0; end
        S_PLO: begin
          nclk = 1'b1;
          if (!ser_din)              nst = S_DHI;
          else if (cnt == LAST_POLL) nst = S_XHI;
          else                       nst = S_PHI;
        end
        S_DHI:  begin nst = S_DLO; nclk = 1'b0; ndbl = 1'b1; end
        S_DLO:  begin nst = (cnt == LAST_RD) ? S_THI : S_DHI; nclk = 1'b1; end
        S_XHI:  begin nst = S_XLO; nclk = 1'b0; ndbl = 1'b1; end
        S_XLO:  begin nst = (cnt == LAST_DUM) ? S_THI : S_XHI; nclk = 1'b1; end
        S_THI:  begin nst = S_TLO; nclk = 1'b0; ndbl = 1'b1; end
        S_TLO: begin
          ndo = 1'b0;
          if (cnt == LAST_RT) begin nst = S_IDLE; nclk = 1'b0; fin = 1'b1; end
          else begin nst = S_THI; nclk = 1'b1; end
        end
        S_WLO:  begin nst = S_WHI; nclk = 1'b1; end
        S_WHI: begin
          nclk = 1'b0;
          if (cnt == LAST_WT) begin nst = S_IDLE; fin = 1'b1; end
          else begin nst = S_WLO; ndbl = 1'b1; end
        end
        S_RHI:  begin nst = S_RLO; nclk = 1'b0; end
        S_RLO: begin
          if (cnt == LAST_RST) begin nst = S_IDLE; fin = 1'b1; end
          else begin nst = S_RHI; nclk = 1'b1; end
        end
        default: begin nst = S_IDLE; nclk = 1'b0; ndo = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; is_wr <= 1'b0; got_rdy <= 1'b0;
      half_q <= HW'(1); done <= 1'b0; rd_ok <= 1'b0; rd_timeout <= 1'b0;
      ser_clk <= 1'b0; ser_dout <= 1'b0;
    end else begin
      done <= fin;
      if (adv) begin
        st <= nst; ser_clk <= nclk; ser_dout <= ndo;
        unique case (st)
          S_IDLE: begin
            sh      <= {req_wdata, (req_addr | {req_index, 1'b0} | DW'(req_write))};
            is_wr   <= req_write;
            half_q  <= half_eff;
            cnt     <= '0;
            got_rdy <= 1'b0;
            rd_ok   <= 1'b0;
            rd_timeout <= 1'b0;
          end
          S_BHI: begin
            sh  <= sh >> 1;
            cnt <= (nst == S_BLO) ? cnt + 1'b1 : '0;
          end
          S_PLO: begin
            if (!ser_din) got_rdy <= 1'b1;
            cnt <= (nst == S_PHI) ? cnt + 1'b1 : '0;
          end
          S_DLO:  cnt <= (nst == S_DHI) ? cnt + 1'b1 : '0;
          S_XLO:  cnt <= (nst == S_XHI) ? cnt + 1'b1 : '0;
          S_TLO: begin
            cnt <= cnt + 1'b1;
            if (fin) begin rd_ok <= got_rdy; rd_timeout <= !got_rdy; end
          end
          S_WHI, S_RLO: cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  rst_cmd_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_RHI || st == S_RLO) |-> !ser_dout);
  // R6
  to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_timeout |-> (rd_data == '0 && !rd_ok));
  // R11
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !ser_clk);
  // R9
  edge_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_clk) |-> $past(adv));
endmodule

// File: tb/xcm_master_tb.sv
`timescale 1ns/1ps
module xcm_master_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_half = 8'd1;
  logic       req = 1'b0, req_write = 1'b0, req_reset = 1'b0;
  logic [7:0] req_addr = '0;
  logic [6:0] req_index = '0;
  logic [7:0] req_wdata = '0;
  logic       done, rd_ok, rd_timeout, ser_clk, ser_dout, ser_din;
  logic [7:0] rd_data;

  int nchk = 0, nfail = 0;
  int rises = 0, base = 0, ready_n = 99, hrun = 0;
  logic [7:0] pat = '0;
  logic rec [0:1023];
  int   hl  [0:1023];

  always #2.5 clk = ~clk;

  xcm_master u_dut (
    .clk(clk), .rst(rst), .cfg_half(cfg_half), .req(req),
    .req_write(req_write), .req_reset(req_reset), .req_addr(req_addr),
    .req_index(req_index), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .rd_ok(rd_ok), .rd_timeout(rd_timeout),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  always @(posedge ser_clk) begin
    rises = rises + 1;
    rec[rises % 1024] = ser_dout;
  end

  always @(negedge clk) begin
    if (ser_clk) hrun = hrun + 1;
    else if (hrun != 0) begin hl[rises % 1024] = hrun; hrun = 0; end
  end

  always_comb begin
    int r;
    r = rises - base;
    if (r < 9 + ready_n)            ser_din = 1'b1;
    else if (r == 9 + ready_n)      ser_din = 1'b0;
    else if (r <= 9 + ready_n + 8)  ser_din = pat[(r - 10 - ready_n) & 7];
    else                            ser_din = 1'b1;
  end

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input bit w, input bit rc, input [7:0] a, input [6:0] ix,
                     input [7:0] d, input [7:0] h, output int cyc);
    @(negedge clk);
    base = rises;
    cfg_half = h; req_write = w; req_reset = rc;
    req_addr = a; req_index = ix; req_wdata = d; req = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) begin
        req_addr = ~a; req_index = ~ix; req_wdata = ~d; cfg_half = h + 8'd3;
      end
    end while (!done && cyc < 20000);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    chk("R10 done single cycle", done, 0);
  endtask

  function automatic int edge_lvl(input int k);
    return rec[(base + k) % 1024];
  endfunction

  task automatic t_reset_state();
    chk("R11 reset clk", ser_clk, 0);
    chk("R11 reset dout", ser_dout, 0);
    chk("R11 reset done", done, 0);
  endtask

  task automatic t_write(input [7:0] a, input [6:0] ix, input [7:0] d, input [7:0] h);
    int cyc, hh;
    logic [7:0] cmd;
    cmd = a | {ix, 1'b0} | 8'd1;
    hh = (h == 0) ? 1 : h;
    ready_n = 99;
    run(1'b1, 1'b0, a, ix, d, h, cyc);
    chk("R3 write edges", rises - base, 19);
    chk("R2 start edge dout", edge_lvl(1), 0);
    for (int i = 0; i < 8; i++) chk("R1 cmd bit", edge_lvl(2 + i), cmd[i]);
    for (int i = 0; i < 8; i++) chk("R3 data bit", edge_lvl(10 + i), d[i]);
    chk("R3 tail1", edge_lvl(18), 0);
    chk("R3 tail2", edge_lvl(19), 0);
    chk("R3 write latency", cyc, 57 * hh + 1);
    chk("R9 high phase start", hl[(base + 1) % 1024], hh);
    chk("R9 high phase bit", hl[(base + 6) % 1024], hh);
    chk("R3 end clk low", ser_clk, 0);
  endtask

  task automatic t_read(input [7:0] a, input [6:0] ix, input [7:0] p, input int n,
                        input [7:0] h);
    int cyc, tot;
    logic [7:0] cmd;
    cmd = a | {ix, 1'b0};
    ready_n = n; pat = p;
    run(1'b0, 1'b0, a, ix, 8'hFF, h, cyc);
    for (int i = 0; i < 8; i++) chk("R1 read cmd bit", edge_lvl(2 + i), cmd[i]);
    if (n <= 10) begin
      tot = 9 + n + 8 + 4;
      chk("R4 read edges", rises - base, tot);
      for (int i = 0; i < n; i++) chk("R4 poll dout high", edge_lvl(10 + i), 1);
      chk("R5 data", rd_data, p);
      chk("R5 ok", rd_ok, 1);
      chk("R5 no timeout", rd_timeout, 0);
      chk("R5 latency", cyc, (65 + 2 * n) * h + 1);
    end else begin
      tot = 9 + 10 + 2 + 4;
      chk("R6 timeout edges", rises - base, tot);
      chk("R6 timeout flag", rd_timeout, 1);
      chk("R6 ok low", rd_ok, 0);
      chk("R6 data zero", rd_data, 0);
      chk("R6 latency", cyc, 67 * h + 1);
    end
    chk("R7 trailer first", edge_lvl(tot - 3), 1);
    for (int i = 0; i < 3; i++) chk("R7 trailer low", edge_lvl(tot - 2 + i), 0);
    chk("R7 end clk low", ser_clk, 0);
  endtask

  task automatic t_rst_cmd(input [7:0] h);
    int cyc, ones;
    ready_n = 99;
    run(1'b0, 1'b1, 8'h40, 7'h1, 8'hFF, h, cyc);
    chk("R8 reset edges", rises - base, 30);
    ones = 0;
    for (int i = 1; i <= 30; i++) ones += edge_lvl(i);
    chk("R8 dout low", ones, 0);
    chk("R8 latency", cyc, 60 * h + 1);
    chk("R8 end clk low", ser_clk, 0);
  endtask

  task automatic t_sync_reset();
    int r0, seen;
    @(negedge clk);
    cfg_half = 8'd2; req_write = 1'b1; req_reset = 1'b0; req = 1'b1;
    repeat (40) @(negedge clk);
    rst = 1'b1; req = 1'b0;
    @(negedge clk);
    chk("R11 abort clk", ser_clk, 0);
    chk("R11 abort dout", ser_dout, 0);
    rst = 1'b0;
    r0 = rises; seen = 0;
    repeat (300) begin @(negedge clk); if (done) seen++; end
    chk("R11 no done after abort", seen, 0);
    chk("R11 no edges after abort", rises - r0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_write(8'h40, 7'h02, 8'hA5, 8'd2);
    t_read(8'h40, 7'h01, 8'h3C, 3, 8'd1);
    t_read(8'h20, 7'h05, 8'h81, 1, 8'd3);
    t_read(8'h40, 7'h00, 8'h5A, 10, 8'd1);
    t_read(8'h40, 7'h02, 8'h00, 99, 8'd2);
    t_rst_cmd(8'd1);
    t_write(8'h00, 7'h7F, 8'h0F, 8'd0);
    t_sync_reset();
    t_write(8'h41, 7'h10, 8'hC3, 8'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule